// File: doc/BRIEF.md
# Stuffed Control Frame Decoder

This block sits behind a line demodulator that has already turned the pulse train into per-bit strobes. It watches the bit-valid, bit-value and frame-break strobes, locks onto an opening 0x7E flag, removes the stuffed bits that the sender inserted into the frame body, and parses a fixed 144-bit body MSB-first. It then checks a closing 0x7E flag. When the closing flag is good, the block publishes every decoded control field, the 16-bit check word and eight reassembled 12-bit channel values, and raises a one-cycle frame-done pulse.

The channel payload is sent as 24 scrambled nibbles, and the block reassembles it into channels. It also flags whether the frame carries the upper bank of channels. A wrong opening or closing flag raises a one-cycle error pulse. After an error the parser ignores the line until the demodulator signals a frame break. The check word is only reported. It is not verified here.

Top module: `ctrl_frame_decoder`

## Requirements
- R1: After reset every field output, `chan_out`, `upper_bank`, `frame_done` and `frame_err` are 0.
- R2: The first 8 kept bits after a break, or after a good closing flag, must be 0x7E (MSB first). If they are not, `frame_err` pulses high for one cycle, starting in the cycle after the clock edge that takes the 8th bit. All further bits are then ignored until `frame_break`: no `frame_done` appears and no output changes.
- R3: Destuffing applies only to the 144 body bits, never to either flag. In the body, a bit that arrives after five consecutive kept 1 bits is discarded, whatever its value, and the run count restarts at zero. A kept 0 also restarts the run. No bit is discarded once the 144th body bit has been taken.
- R4: The body fields are laid out from the first bit to the last as follows: `model_id`[7:0], `link_mode`[1:0] (0 FCC, 1 EU, 2 EU+, 3 AU+), `range_chk`, `failsafe`, `region`[2:0], `bind_req`, `flags_b`[7:0], the 96-bit channel block, `rsvd_bit`, `ext_region`, `port_off`, `power_lvl`[1:0], `high_rx`, `telem_off`, `ext_ant` and `crc`[15:0]. Each field is MSB first.
- R5: The channel block is split into nibbles n0..n23 in arrival order. Group k (k = 0..3) holds g0..g5 = n(6k)..n(6k+5). Channel 2k = {g3,g1,g0} and channel 2k+1 = {g4,g5,g2}. Channel i is presented at `chan_out[12i+11:12i]`.
- R6: `upper_bank` is 1 exactly when some even-numbered channel (the first channel of a group) is greater than 2048. The value 2048 itself does not set it, and odd-numbered channels never set it.
- R7: A closing flag of 0x7E gives a one-cycle `frame_done` pulse, starting in the cycle after the edge that takes its last bit, and updates all fields in that same cycle. The parser then waits for a new opening flag. Any other closing value gives a `frame_err` pulse instead, and the block enters the error state of R2.
- R8: `frame_break` at any point clears the run count, the flag and body counters and the error state, so that the next bits are treated as an opening flag. A bit strobed in the same cycle as the break is dropped.
- R9: Field outputs hold their values between `frame_done` pulses. Errors, breaks and partial frames do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | One-cycle strobe: a demodulated bit is present |
| bit_value | input | 1 | Value of the strobed bit |
| frame_break | input | 1 | One-cycle strobe: line idle gap seen, restart parsing |
| model_id | output | 8 | Model identifier |
| link_mode | output | 2 | Regional link mode code |
| range_chk | output | 1 | Range-check request |
| failsafe | output | 1 | Failsafe request |
| region | output | 3 | Country code |
| bind_req | output | 1 | Bind request |
| flags_b | output | 8 | Second flags byte |
| chan_out | output | 96 | Eight 12-bit channels, channel 0 in the low bits |
| upper_bank | output | 1 | Frame carries channels 9 to 16 |
| rsvd_bit | output | 1 | Reserved bit |
| ext_region | output | 1 | Extended-region flag |
| port_off | output | 1 | Disable telemetry port |
| power_lvl | output | 2 | Power level |
| high_rx | output | 1 | High-channel receive |
| telem_off | output | 1 | Telemetry off |
| ext_ant | output | 1 | External antenna select |
| crc | output | 16 | Check word as received |
| frame_done | output | 1 | One-cycle pulse: good frame decoded |
| frame_err | output | 1 | One-cycle pulse: bad opening or closing flag |

## Verification
A run-of-ones count that is off by one, or destuffing that stays on during a flag, moves every later body bit. This shows in the first fields after the error and usually turns the closing flag bad, so `frame_err` pulses in place of `frame_done` about eight bits later. A wrong body position count, or a wrong phase, shows at the very end of the frame as a missing or misplaced pulse. A wrong nibble mapping shows only in `chan_out` and `upper_bank`, so frames whose channels differ in every nibble, plus first-channel values of exactly 2048 and 2049, are needed to expose it. A parser that leaves the error state without a break shows as a stray `frame_done`.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int FLAG_W = 8;
  localparam logic [FLAG_W-1:0] FLAG_WORD = 8'h7E;
  localparam int CH_W = 12;
  localparam int N_CH = 8;
  localparam int NIB_W = 4;
  localparam int BLK_W = CH_W * N_CH;
  localparam int BODY_BITS = 144;
  localparam logic [CH_W-1:0] BANK_LIMIT = 12'd2048;

  typedef enum logic [1:0] {PH_HUNT, PH_BODY, PH_STOP, PH_ERR} phase_t;

  typedef struct packed {
    logic [7:0]       model;
    logic [1:0]       mode;
    logic             rng;
    logic             fsafe;
    logic [2:0]       cc;
    logic             bnd;
    logic [7:0]       flg;
    logic [BLK_W-1:0] chans;
    logic             rsv;
    logic             xreg;
    logic             poff;
    logic [1:0]       pwr;
    logic             hrx;
    logic             toff;
    logic             xant;
    logic [15:0]      chk;
  } frame_t;

  // nibble j in arrival order (j = 0 is the first nibble received)
  function automatic logic [NIB_W-1:0] nib_at(input logic [BLK_W-1:0] blk, input int j);
    logic [BLK_W-1:0] s;
    s = blk << (NIB_W * j);
    return s[BLK_W-1 -: NIB_W];
  endfunction

  function automatic logic [CH_W-1:0] chan_of(input logic [BLK_W-1:0] blk, input int idx);
    int g;
    g = (idx / 2) * 6;
    if (idx % 2 == 0) return {nib_at(blk, g + 3), nib_at(blk, g + 1), nib_at(blk, g)};
    else              return {nib_at(blk, g + 4), nib_at(blk, g + 5), nib_at(blk, g + 2)};
  endfunction
endpackage

// File: rtl/cfd_destuff.sv
module cfd_destuff #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_valid,
  input  logic bit_value,
  input  logic stuff_en,
  output logic keep
);
  localparam int CW = $clog2(RUN_LEN + 2);
  localparam logic [CW-1:0] RUN_HIT = CW'(RUN_LEN);
  localparam logic [CW-1:0] RUN_SAT = {CW{1'b1}};

  logic [CW-1:0] ones;
  logic          drop;

  assign drop = bit_valid && stuff_en && (ones == RUN_HIT);
  assign keep = bit_valid && !drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ones <= '0;
    else if (clr)        ones <= '0;
    else if (drop)       ones <= '0;
    else if (keep) begin
      if (!bit_value)    ones <= '0;
      else if (ones != RUN_SAT) ones <= ones + 1'b1;
    end
  end

  // R3: inside the body the run never grows past the stuffing limit
  p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_en && !clr) |-> (ones <= RUN_HIT));
endmodule

// File: rtl/cfd_parser.sv
module cfd_parser
  import cfd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 brk,
  input  logic                 keep,
  input  logic                 bit_value,
  output logic                 stuff_en,
  output logic [BODY_BITS-1:0] body,
  output logic                 done_now,
  output logic                 err_now
);
  localparam int FCW = $clog2(FLAG_W);
  localparam int PW  = $clog2(BODY_BITS);
  localparam logic [FCW-1:0] FC_LAST  = FCW'(FLAG_W - 1);
  localparam logic [PW-1:0]  POS_LAST = PW'(BODY_BITS - 1);

  phase_t            phase;
  logic [FLAG_W-1:0] fword;
  logic [FCW-1:0]    fcnt;
  logic [PW-1:0]     pos;
  logic [FLAG_W-1:0] fnext;
  logic              flag_last;
  logic              in_flag;

  assign fnext     = {fword[FLAG_W-2:0], bit_value};
  assign in_flag   = (phase == PH_HUNT) || (phase == PH_STOP);
  assign flag_last = keep && !brk && in_flag && (fcnt == FC_LAST);
  assign done_now  = flag_last && (phase == PH_STOP) && (fnext == FLAG_WORD);
  assign err_now   = flag_last && (fnext != FLAG_WORD);
  assign stuff_en  = (phase == PH_BODY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_HUNT;
      fword <= '0;
      fcnt  <= '0;
      pos   <= '0;
      body  <= '0;
    end else if (brk) begin
      phase <= PH_HUNT;
      fword <= '0;
      fcnt  <= '0;
      pos   <= '0;
    end else if (keep) begin
      case (phase)
        PH_HUNT: begin
          fword <= fnext;
          fcnt  <= fcnt + 1'b1;
          pos   <= '0;
          if (fcnt == FC_LAST) phase <= (fnext == FLAG_WORD) ? PH_BODY : PH_ERR;
        end
        PH_BODY: begin
          body <= {body[BODY_BITS-2:0], bit_value};
          pos  <= pos + 1'b1;
          if (pos == POS_LAST) begin
            phase <= PH_STOP;
            fcnt  <= '0;
          end
        end
        PH_STOP: begin
          fword <= fnext;
          fcnt  <= fcnt + 1'b1;
          if (fcnt == FC_LAST) phase <= (fnext == FLAG_WORD) ? PH_HUNT : PH_ERR;
        end
        default: ;
      endcase
    end
  end

  // R8: a break always re-arms flag hunting from bit zero
  p_break_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> (phase == PH_HUNT) && (fcnt == '0));
  // R2: the error state is left only through a break
  p_err_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ERR) && !brk |=> (phase == PH_ERR));
  // R4: body position stays inside the fixed layout
  p_body_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BODY) |-> (pos <= POS_LAST));
  // R7: a completed frame only comes out of the closing-flag phase
  p_done_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_now |=> (phase == PH_HUNT));
endmodule

// File: rtl/ctrl_frame_decoder.sv
module ctrl_frame_decoder
  import cfd_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_value,
  input  logic              frame_break,
  output logic [7:0]        model_id,
  output logic [1:0]        link_mode,
  output logic              range_chk,
  output logic              failsafe,
  output logic [2:0]        region,
  output logic              bind_req,
  output logic [7:0]        flags_b,
  output logic [BLK_W-1:0]  chan_out,
  output logic              upper_bank,
  output logic              rsvd_bit,
  output logic              ext_region,
  output logic              port_off,
  output logic [1:0]        power_lvl,
  output logic              high_rx,
  output logic              telem_off,
  output logic              ext_ant,
  output logic [15:0]       crc,
  output logic              frame_done,
  output logic              frame_err
);
  logic                 keep;
  logic                 stuff_en;
  logic                 done_now;
  logic                 err_now;
  logic [BODY_BITS-1:0] body;
  frame_t               fq;

  cfd_destuff #(.RUN_LEN(RUN_LEN)) u_destuff (
    .clk(clk), .rst_n(rst_n), .clr(frame_break),
    .bit_valid(bit_valid), .bit_value(bit_value),
    .stuff_en(stuff_en), .keep(keep)
  );

  cfd_parser u_parser (
    .clk(clk), .rst_n(rst_n), .brk(frame_break),
    .keep(keep), .bit_value(bit_value),
    .stuff_en(stuff_en), .body(body),
    .done_now(done_now), .err_now(err_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fq         <= '0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      if (done_now) fq <= frame_t'(body);
      frame_done <= done_now;
      frame_err  <= err_now;
    end
  end

  assign model_id   = fq.model;
  assign link_mode  = fq.mode;
  assign range_chk  = fq.rng;
  assign failsafe   = fq.fsafe;
  assign region     = fq.cc;
  assign bind_req   = fq.bnd;
  assign flags_b    = fq.flg;
  assign rsvd_bit   = fq.rsv;
  assign ext_region = fq.xreg;
  assign port_off   = fq.poff;
  assign power_lvl  = fq.pwr;
  assign high_rx    = fq.hrx;
  assign telem_off  = fq.toff;
  assign ext_ant    = fq.xant;
  assign crc        = fq.chk;

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    assign chan_out[i*CH_W +: CH_W] = chan_of(fq.chans, i);
  end

  always_comb begin
    upper_bank = 1'b0;
    for (int k = 0; k < N_CH; k += 2)
      if (chan_out[k*CH_W +: CH_W] > BANK_LIMIT) upper_bank = 1'b1;
  end

  // R9: outputs move only on a completed frame
  p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_now |=> $stable(chan_out) && $stable(crc) && $stable(model_id) && $stable(upper_bank));
  // R7: done and error never coincide
  p_pulses_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_err));
  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R2: error is a single-cycle pulse
  p_err_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
endmodule

// File: tb/test_ctrl_frame_decoder.sv
module test_ctrl_frame_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_value = 1'b0, frame_break = 1'b0;
  logic [7:0] model_id, flags_b;
  logic [1:0] link_mode, power_lvl;
  logic [2:0] region;
  logic range_chk, failsafe, bind_req, upper_bank, rsvd_bit, ext_region, port_off;
  logic high_rx, telem_off, ext_ant, frame_done, frame_err;
  logic [95:0] chan_out;
  logic [15:0] crc;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_frame_decoder i_ctrl_frame_decoder (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_value(bit_value),
    .frame_break(frame_break), .model_id(model_id), .link_mode(link_mode),
    .range_chk(range_chk), .failsafe(failsafe), .region(region), .bind_req(bind_req),
    .flags_b(flags_b), .chan_out(chan_out), .upper_bank(upper_bank), .rsvd_bit(rsvd_bit),
    .ext_region(ext_region), .port_off(port_off), .power_lvl(power_lvl), .high_rx(high_rx),
    .telem_off(telem_off), .ext_ant(ext_ant), .crc(crc), .frame_done(frame_done),
    .frame_err(frame_err)
  );

  // {model8, mode2, rng, fs, cc3, bind, flags8, tail8, crc16, seed12}
  localparam logic [59:0] VEC [0:3] = '{
    {8'h12, 2'd0, 1'b0, 1'b1, 3'h5, 1'b0, 8'hA5, 8'hA6, 16'hBEEF, 12'h001},
    {8'hFF, 2'd3, 1'b1, 1'b1, 3'h7, 1'b1, 8'hFF, 8'hFF, 16'hFFFF, 12'hFFF},
    {8'h00, 2'd1, 1'b0, 1'b0, 3'h0, 1'b0, 8'h00, 8'h00, 16'h0000, 12'h000},
    {8'h3C, 2'd2, 1'b1, 1'b0, 3'h2, 1'b1, 8'h7E, 8'h5A, 16'h7E7E, 12'h5A5}
  };

  int checks = 0, failures = 0, n_done = 0, n_err = 0;
  bit finished = 1'b0;
  logic [11:0] cset [0:7];
  logic [160:0] snap_exp;

  always @(negedge clk) begin
    if (frame_done) n_done++;
    if (frame_err) n_err++;
  end

  task automatic chk(input string tag, input logic [160:0] act, input logic [160:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [160:0] port_snap();
    return {model_id, link_mode, range_chk, failsafe, region, bind_req, flags_b,
            rsvd_bit, ext_region, port_off, power_lvl, high_rx, telem_off, ext_ant,
            crc, chan_out, upper_bank};
  endfunction

  task automatic seed_chans(input logic [11:0] seed);
    for (int i = 0; i < 8; i++) cset[i] = 12'(12'h111 * i) ^ seed;
  endtask

  function automatic logic [95:0] chan_block();
    logic [3:0] n [0:23];
    logic [95:0] blk;
    for (int k = 0; k < 4; k++) begin
      n[6*k+0] = cset[2*k][3:0];   n[6*k+1] = cset[2*k][7:4];   n[6*k+3] = cset[2*k][11:8];
      n[6*k+2] = cset[2*k+1][3:0]; n[6*k+5] = cset[2*k+1][7:4]; n[6*k+4] = cset[2*k+1][11:8];
    end
    blk = '0;
    for (int j = 0; j < 24; j++) blk = {blk[91:0], n[j]};
    return blk;
  endfunction

  function automatic logic [95:0] flat_chans();
    logic [95:0] f;
    for (int i = 0; i < 8; i++) f[12*i +: 12] = cset[i];
    return f;
  endfunction

  function automatic logic exp_upper();
    logic u = 1'b0;
    for (int k = 0; k < 8; k += 2) if (cset[k] > 12'd2048) u = 1'b1;
    return u;
  endfunction

  task automatic send_bit(input logic b, input bit gap);
    bit_valid = 1'b1; bit_value = b;
    @(negedge clk);
    bit_valid = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic pulse_break();
    frame_break = 1'b1;
    @(negedge clk);
    frame_break = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [143:0] body, input logic [7:0] of,
                            input logic [7:0] cf, input logic stuff_val);
    int ones = 0;
    for (int i = 7; i >= 0; i--) send_bit(of[i], (i % 2) == 0);
    for (int i = 143; i >= 0; i--) begin
      send_bit(body[i], (i % 3) == 0);
      if (body[i]) ones++; else ones = 0;
      if (ones == 5 && i > 0) begin
        send_bit(stuff_val, 1'b0);
        ones = 0;
      end
    end
    for (int i = 7; i >= 0; i--) send_bit(cf[i], 1'b0);
  endtask

  function automatic logic [143:0] make_body(input logic [59:0] v);
    return {v[59:36], chan_block(), v[35:28], v[27:12]};
  endfunction

  function automatic logic [160:0] make_snap(input logic [59:0] v);
    return {v[59:36], v[35:28], v[27:12], flat_chans(), exp_upper()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset fields", port_snap(), '0);
    chk("R1 reset pulses", {frame_done, frame_err}, '0);

    // table-driven frames
    for (int v = 0; v < 4; v++) begin
      seed_chans(VEC[v][11:0]);
      d0 = n_done;
      send_frame(make_body(VEC[v]), 8'h7E, 8'h7E, v[0]);
      chk("R7 done pulse on good close", frame_done, 1'b1);
      chk("R4 header fields", {model_id, link_mode, range_chk, failsafe, region, bind_req, flags_b},
          VEC[v][59:36]);
      chk("R4 tail fields", {rsvd_bit, ext_region, port_off, power_lvl, high_rx, telem_off, ext_ant},
          VEC[v][35:28]);
      chk("R4 crc", crc, VEC[v][27:12]);
      chk("R5 channel reassembly", chan_out, flat_chans());
      chk("R6 upper bank", upper_bank, exp_upper());
      snap_exp = make_snap(VEC[v]);
      @(negedge clk);
      chk("R9 fields held after done", port_snap(), snap_exp);
      chk("R7 single done pulse", n_done - d0, 1);
    end
    chk("R3 heavy-stuff frame and unstuffed flags", n_err, 0);

    // R6 boundary: 2048 on a first channel, large odd channel
    for (int i = 0; i < 8; i++) cset[i] = 12'h100;
    cset[0] = 12'd2048; cset[1] = 12'hFFF;
    send_frame(make_body(VEC[0]), 8'h7E, 8'h7E, 1'b0);
    chk("R6 2048 and odd channel do not set upper", upper_bank, 1'b0);
    cset[2] = 12'd2049;
    send_frame(make_body(VEC[0]), 8'h7E, 8'h7E, 1'b0);
    chk("R6 2049 sets upper", upper_bank, 1'b1);
    chk("R5 boundary channels", chan_out, flat_chans());
    snap_exp = port_snap();

    // R2: bad opening flag
    for (int i = 7; i >= 0; i--) send_bit(8'h7F >> i, 1'b0);
    chk("R2 err pulse on bad open", frame_err, 1'b1);
    d0 = n_done;
    seed_chans(12'h321);
    send_frame(make_body(VEC[3]), 8'h7E, 8'h7E, 1'b0);
    @(negedge clk);
    chk("R2 bits ignored in error state", n_done - d0, 0);
    chk("R9 fields untouched by ignored frame", port_snap(), snap_exp);

    // R8: break leaves error, then good frame
    pulse_break();
    send_frame(make_body(VEC[3]), 8'h7E, 8'h7E, 1'b0);
    chk("R8 frame after break decodes", port_snap(), make_snap(VEC[3]));
    snap_exp = make_snap(VEC[3]);

    // R7: bad closing flag
    seed_chans(12'h0F0);
    send_frame(make_body(VEC[0]), 8'h7E, 8'h7C, 1'b0);
    chk("R7 err pulse on bad close", frame_err, 1'b1);
    chk("R9 fields kept after bad close", port_snap(), snap_exp);
    pulse_break();

    // R8: break in the middle of a body, bit strobed with the break dropped
    for (int i = 7; i >= 0; i--) send_bit(8'h7E >> i, 1'b0);
    for (int i = 0; i < 40; i++) send_bit(i[0], 1'b0);
    frame_break = 1'b1; bit_valid = 1'b1; bit_value = 1'b0;
    @(negedge clk);
    frame_break = 1'b0; bit_valid = 1'b0;
    seed_chans(12'hABC);
    send_frame(make_body(VEC[1]), 8'h7E, 8'h7E, 1'b1);
    chk("R8 mid-frame break then clean decode", port_snap(), make_snap(VEC[1]));
    chk("R2 no spurious error pulses", n_err, 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule